// File: doc/BRIEF.md
# System Watchdog Timer with Power-Mode Auto-Clear

This block is the system watchdog of a power-management controller. Software reaches it through a small byte-wide register port. Through that port it can:

- switch the watchdog on or off;
- choose one of four fixed timeout lengths;
- kick the countdown so that it starts over.

A free-running prescaler turns the system clock into a one-second tick. A seconds counter compares the elapsed time against the chosen length.

While the system is asleep or powered down, the counter can be held at zero by two auto-clear bits, so that a quiet system does not trip the watchdog. The bit for the power-down case is present only when the `HAS_OFF_CLR` parameter is set. When the count runs out, the block issues a one-cycle request. A separate action bit decides whether that request asks for a restart or for a power-off. The downstream sequencer acts on the request.

Top module: `sys_watchdog`

## Requirements
- R1: After reset, the control register (address 0) reads 0x06. In that register bit0 is the enable bit, bits[2:1] are the period code, bit3 is the sleep auto-clear bit and bit4 is the off auto-clear bit. So after reset the watchdog is disabled, the period code is 11 (128 s) and both auto-clear bits are 0. The action register (address 2) and address 3 read 0, and neither request output pulses.
- R2: The enable bit (control bit0) reads back as written. While it is 0, no expiry request is produced.
- R3: Period codes 00, 01, 10 and 11 select 2, 16, 64 and 128 ticks of `TICK_DIV` clocks each. The first request goes high P*TICK_DIV clock edges after the edge that wrote the control register with the enable bit set.
- R4: Writing 1 to bit0 of the kick register (address 1) restarts the countdown from zero. The request then comes P*TICK_DIV edges after the kick edge. Address 1 always reads 0.
- R5: Every write to the control register restarts the countdown from zero, whether or not the period changes.
- R6: While the sleep auto-clear bit (control bit3) is 1 and `sleep_mode` is high, the counter is held at zero and no request is produced. With the bit at 0, `sleep_mode` has no effect.
- R7: While the off auto-clear bit (control bit4) is 1 and `off_mode` is high, the counter is held at zero. With `HAS_OFF_CLR`=0, bit4 reads 0 and `off_mode` has no effect.
- R8: At expiry, if action register bit0 is 1 the block pulses `restart_req`; otherwise it pulses `poweroff_req`. The two are never high together.
- R9: Each request lasts one clock. The count then restarts, so the next request follows a full period later if nothing intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| sleep_mode | input | 1 | System is in sleep mode |
| off_mode | input | 1 | System is in off mode |
| restart_req | output | 1 | One-cycle restart request on expiry |
| poweroff_req | output | 1 | One-cycle power-off request on expiry |

## Verification
A corrupted prescaler or seconds counter would show as a request arriving at the wrong time. The bench therefore measures, to the exact clock edge, how far each request falls from the write, kick or mode release that started the count.

A clear condition that fails to hold the counter would show as a request inside a window that should stay quiet, within one period of the stimulus. A wrong action bit or a stuck pulse would show on the very cycle of expiry or the cycle after it.

// File: rtl/sys_watchdog.sv
module sys_watchdog #(
  parameter int TICK_DIV    = 50_000_000,
  parameter bit HAS_OFF_CLR = 1'b1,
  parameter int PER0        = 2,
  parameter int PER1        = 16,
  parameter int PER2        = 64,
  parameter int PER3        = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sleep_mode,
  input  logic       off_mode,
  output logic       restart_req,
  output logic       poweroff_req
);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam int SW = $clog2(PER3 + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  logic          en, slp_clr, off_clr, act;
  logic [1:0]    per;
  logic [PW-1:0] presc;
  logic [SW-1:0] secs, per_len;
  logic          wr_ctrl, wr_kick, wr_act, hold, tick, fire;

  assign wr_ctrl = reg_wr && reg_addr == 2'd0;
  assign wr_kick = reg_wr && reg_addr == 2'd1 && reg_wdata[0];
  assign wr_act  = reg_wr && reg_addr == 2'd2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en      <= 1'b0;
      per     <= 2'b11;
      slp_clr <= 1'b0;
      act     <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en      <= reg_wdata[0];
        per     <= reg_wdata[2:1];
        slp_clr <= reg_wdata[3];
      end
      if (wr_act) act <= reg_wdata[0];
    end

  generate
    if (HAS_OFF_CLR) begin : g_offclr
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)       off_clr <= 1'b0;
        else if (wr_ctrl) off_clr <= reg_wdata[4];
    end else begin : g_no_offclr
      assign off_clr = 1'b0;
    end
  endgenerate

  always_comb
    case (per)
      2'd0:    per_len = SW'(PER0);
      2'd1:    per_len = SW'(PER1);
      2'd2:    per_len = SW'(PER2);
      default: per_len = SW'(PER3);
    endcase

  assign hold = !en || wr_ctrl || wr_kick || (slp_clr && sleep_mode) || (off_clr && off_mode);
  assign tick = presc == PRE_LAST;
  assign fire = !hold && tick && secs == per_len - SW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      presc <= '0;
      secs  <= '0;
    end else if (hold) begin
      presc <= '0;
      secs  <= '0;
    end else if (tick) begin
      presc <= '0;
      secs  <= fire ? '0 : secs + SW'(1);
    end else begin
      presc <= presc + PW'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      restart_req  <= 1'b0;
      poweroff_req <= 1'b0;
    end else begin
      restart_req  <= fire && act;
      poweroff_req <= fire && !act;
    end

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = {3'b000, off_clr, slp_clr, per, en};
      2'd2:    reg_rdata = {7'd0, act};
      default: reg_rdata = 8'h00;
    endcase

  AST_SECS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) secs < per_len); // R3
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(restart_req || poweroff_req)); // R2
  AST_KICK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 2'd1 |-> reg_rdata == 8'h00); // R4
  AST_SLEEP_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (slp_clr && sleep_mode) |=> !(restart_req || poweroff_req)); // R6
  AST_OFF_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (off_clr && off_mode) |=> !(restart_req || poweroff_req)); // R7
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(restart_req && poweroff_req)); // R8
  AST_RESTART_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> !restart_req); // R9
  AST_POWEROFF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    poweroff_req |=> !poweroff_req); // R9
endmodule

// File: tb/sys_watchdog_test.sv
module sys_watchdog_test;
  localparam int DIV = 4;
  localparam int V_CODE [4] = '{0, 1, 2, 3};
  localparam int V_ACT  [4] = '{1, 0, 1, 0};
  localparam int V_CYC  [4] = '{2*DIV, 16*DIV, 64*DIV, 128*DIV};

  logic clk = 0, rst_n = 0, reg_wr = 0, sleep_mode = 0, off_mode = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, rdata_b;
  logic restart_req, poweroff_req, restart_b, poweroff_b;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  sys_watchdog #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sleep_mode(sleep_mode), .off_mode(off_mode),
    .restart_req(restart_req), .poweroff_req(poweroff_req));

  sys_watchdog #(.TICK_DIV(DIV), .HAS_OFF_CLR(1'b0)) uut_b (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_b), .sleep_mode(sleep_mode), .off_mode(off_mode),
    .restart_req(restart_b), .poweroff_req(poweroff_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk);
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int va, output int vb);
    @(negedge clk); reg_addr = a; #1;
    va = int'(reg_rdata); vb = int'(rdata_b);
  endtask

  task automatic wait_pulse(input int limit, output int n, output bit r, output bit p);
    r = 0; p = 0; n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); @(negedge clk);
      if (restart_req || poweroff_req) begin
        n = i; r = restart_req; p = poweroff_req;
        return;
      end
    end
  endtask

  task automatic observe(input int cyc, output int fa, output int fb);
    fa = 0; fb = 0;
    for (int i = 1; i <= cyc; i++) begin
      @(posedge clk); @(negedge clk);
      if (fa == 0 && (restart_req || poweroff_req)) fa = i;
      if (fb == 0 && (restart_b || poweroff_b)) fb = i;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int va, vb, n, fa, fb;
    bit r, p;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    rd(2'd0, va, vb);
    chk(va == 6 && vb == 6, "R1 ctrl reset", va, 6);
    rd(2'd2, va, vb);
    chk(va == 0, "R1 action reset", va, 0);
    rd(2'd3, va, vb);
    chk(va == 0, "R1 addr3", va, 0);
    observe(600, fa, fb);
    chk(fa == 0 && fb == 0, "R1 R2 no request after reset", fa, 0);

    for (int k = 0; k < 4; k++) begin
      wr(2'd2, 8'(V_ACT[k]));
      wr(2'd0, 8'(1 | (V_CODE[k] << 1)));
      wait_pulse(V_CYC[k] + 4, n, r, p);
      chk(n == V_CYC[k], "R3 expiry time", n, V_CYC[k]);
      chk(r == V_ACT[k][0] && p == !V_ACT[k][0], "R8 action select", int'(r), V_ACT[k]);
      @(posedge clk); @(negedge clk);
      chk(!(restart_req || poweroff_req), "R9 single cycle", int'(restart_req | poweroff_req), 0);
      wait_pulse(V_CYC[k] + 4, n, r, p);
      chk(n == V_CYC[k] - 1, "R9 reload period", n, V_CYC[k] - 1);
      wr(2'd0, 8'(V_CODE[k] << 1));
    end

    wr(2'd2, 8'h01);
    wr(2'd0, 8'h01);
    observe(4, fa, fb);
    wr(2'd0, 8'h01);
    wait_pulse(20, n, r, p);
    chk(n == 2*DIV, "R5 ctrl write restarts", n, 2*DIV);

    wr(2'd0, 8'h01);
    observe(4, fa, fb);
    wr(2'd1, 8'h01);
    wait_pulse(20, n, r, p);
    chk(n == 2*DIV, "R4 kick restarts", n, 2*DIV);
    rd(2'd1, va, vb);
    chk(va == 0, "R4 kick reads 0", va, 0);

    wr(2'd0, 8'h01);
    rd(2'd0, va, vb);
    chk(va == 1, "R2 enable reads back", va, 1);
    wr(2'd0, 8'h00);
    observe(40, fa, fb);
    chk(fa == 0, "R2 disabled quiet", fa, 0);
    rd(2'd0, va, vb);
    chk(va == 0, "R2 disable reads back", va, 0);

    wr(2'd0, 8'h09);
    sleep_mode = 1;
    observe(30, fa, fb);
    chk(fa == 0, "R6 sleep holds", fa, 0);
    sleep_mode = 0;
    wait_pulse(20, n, r, p);
    chk(n == 2*DIV, "R6 count after sleep release", n, 2*DIV);
    wr(2'd0, 8'h01);
    sleep_mode = 1;
    wait_pulse(20, n, r, p);
    chk(n == 2*DIV, "R6 sleep ignored when bit clear", n, 2*DIV);
    sleep_mode = 0;

    wr(2'd0, 8'h11);
    off_mode = 1;
    observe(2*DIV, fa, fb);
    chk(fa == 0, "R7 off holds", fa, 0);
    chk(fb == 2*DIV, "R7 off ignored without option", fb, 2*DIV);
    off_mode = 0;
    rd(2'd0, va, vb);
    chk(va == 8'h11, "R7 off bit reads back", va, 8'h11);
    chk(vb == 8'h01, "R7 off bit absent", vb, 8'h01);
    wr(2'd0, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule